// File: doc/BRIEF.md
# Processor Reset Initialization Sequencer

This block walks a processor core from power-on reset to the moment it may start fetching instructions. It holds in a reset-wait state while the active-low reset is low. After release it waits for the PLL to report lock. It then performs two handshakes on a system-driven clock-forward reset line. The first handshake brackets the start of self-test and serial ROM loading. The second gates the external clock enable. A fixed post-clock delay follows, after which the run output rises.

The self-test engine, the ROM loader and the PLL are outside the block and are seen only through start and done signals. If the system is not holding clock-forward reset high when the sequencer arrives at the first handshake, this is flagged as a protocol violation. That flag stays set until the next reset, and the sequence continues.

The states are, in order:

- ST_WAIT_RESET, which leaves on the first clock with reset released.
- ST_PLL_RAMP, which leaves when lock is seen.
- ST_CFR_HOLD, which leaves when clock-forward reset is low.
- ST_TEST_START, which lasts one cycle.
- ST_TEST_WAIT, which leaves when both done flags have been seen.
- ST_CFR_RELEASE, which leaves when clock-forward reset is low.
- ST_CLK_DELAY, which leaves when the delay expires.
- ST_RUN, which is terminal.

Top module: `boot_sequencer`

## Requirements
- R1: While `rst_n` is low, the block is in the reset-wait state with `rom_oe_n`=1 and every other output 0. A low level on `rst_n` takes effect asynchronously from any state.
- R2: After reset release, `rom_oe_n` stays 1 until `pll_locked` is sampled high in the PLL ramp state. `rom_oe_n` falls in the cycle after that sample.
- R3: If `sys_fwd_reset` is 0 at the edge where lock is accepted, `proto_err` rises in the next cycle and stays 1 until reset. Otherwise it stays 0. The sequence proceeds in both cases.
- R4: While the sequencer waits in the first handshake, `rom_oe_n` stays 0 and no start pulse is issued as long as `sys_fwd_reset` is 1.
- R5: In the cycle after `sys_fwd_reset` is sampled 0 in the first handshake, `selftest_start` and `romload_start` are both 1 for exactly one cycle.
- R6: The two done flags may arrive in either order or in the same cycle. `rom_oe_n` returns to 1 in the cycle after the later of the two is sampled.
- R7: Done flags sampled outside the load-wait state, including before the start pulses, have no effect.
- R8: `ext_clk_en` stays 0 until `sys_fwd_reset` is sampled 0 after loading completes. It rises in the next cycle.
- R9: `core_run` rises exactly 264 clock cycles after `ext_clk_en` rises.
- R10: Once `ext_clk_en` and `core_run` are high, they hold until reset. Changes on `sys_fwd_reset` and `pll_locked` no longer matter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sys_fwd_reset | input | 1 | Clock-forward reset handshake from the system, active high |
| pll_locked | input | 1 | PLL lock indication |
| selftest_done | input | 1 | Self-test completion flag |
| romload_done | input | 1 | Serial ROM load completion flag |
| rom_oe_n | output | 1 | Serial ROM output enable, active low |
| selftest_start | output | 1 | One-cycle self-test start pulse |
| romload_start | output | 1 | One-cycle ROM load start pulse |
| ext_clk_en | output | 1 | External clock enable |
| core_run | output | 1 | Instruction start permission |
| proto_err | output | 1 | Sticky protocol violation flag |

## Verification
The hardest situation to reach is the load-wait state with stale done pulses already applied, combined with a second handshake that holds the clock-forward line high. Reaching it requires driving the line high again while loading is still in progress. Each trial draws its lock wait, handshake hold times, done arrival cycles and the option to pulse done flags early from a seeded `$urandom`. A few directed trials force the protocol-violation path, same-cycle done flags and zero-length holds.

// File: rtl/bootseq_pkg.sv
package bootseq_pkg;

    typedef enum logic [2:0] {
        ST_WAIT_RESET  = 3'd0,
        ST_PLL_RAMP    = 3'd1,
        ST_CFR_HOLD    = 3'd2,
        ST_TEST_START  = 3'd3,
        ST_TEST_WAIT   = 3'd4,
        ST_CFR_RELEASE = 3'd5,
        ST_CLK_DELAY   = 3'd6,
        ST_RUN         = 3'd7
    } seq_state_e;

    localparam int DONE_SOURCES = 2;

endpackage

// File: rtl/bootseq_done_tracker.sv
module bootseq_done_tracker #(
    parameter int N_SRC = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic [N_SRC-1:0] done_in,
    output logic             all_done
);

    logic [N_SRC-1:0] seen;
    logic [N_SRC-1:0] seen_or_now;

    for (genvar g = 0; g < N_SRC; g++) begin : g_src
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                seen[g] <= 1'b0;
            end else if (clr) begin
                seen[g] <= 1'b0;
            end else if (en && done_in[g]) begin
                seen[g] <= 1'b1;
            end
        end
        assign seen_or_now[g] = seen[g] | (en & done_in[g]);
    end

    assign all_done = en & (&seen_or_now);

    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (seen == '0)) else $error("done tracker not cleared"); // R7

endmodule

// File: rtl/bootseq_delay_counter.sv
module bootseq_delay_counter #(
    parameter int DELAY_CYCLES = 264
) (
    input  logic clk,
    input  logic rst_n,
    input  logic count_en,
    output logic expired
);

    localparam int CW = (DELAY_CYCLES > 1) ? $clog2(DELAY_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(DELAY_CYCLES - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!count_en) begin
            cnt <= '0;
        end else if (cnt != LAST) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expired = count_en && (cnt == LAST);

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST) else $error("delay counter overran"); // R9

    AST_CNT_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        !count_en |=> (cnt == '0)) else $error("delay counter not restarted"); // R9

endmodule

// File: rtl/boot_sequencer.sv
module boot_sequencer
    import bootseq_pkg::*;
#(
    parameter int DELAY_CYCLES = 264
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sys_fwd_reset,
    input  logic pll_locked,
    input  logic selftest_done,
    input  logic romload_done,
    output logic rom_oe_n,
    output logic selftest_start,
    output logic romload_start,
    output logic ext_clk_en,
    output logic core_run,
    output logic proto_err
);

    seq_state_e state, state_nxt;
    logic       both_done;
    logic       delay_expired;
    logic       err_q;

    // Done-flag collection during the load-wait state
    bootseq_done_tracker #(.N_SRC(DONE_SOURCES)) u_done (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (state == ST_TEST_START),
        .en       (state == ST_TEST_WAIT),
        .done_in  ({romload_done, selftest_done}),
        .all_done (both_done)
    );

    // Post-clock-start delay
    bootseq_delay_counter #(.DELAY_CYCLES(DELAY_CYCLES)) u_delay (
        .clk      (clk),
        .rst_n    (rst_n),
        .count_en (state == ST_CLK_DELAY),
        .expired  (delay_expired)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_WAIT_RESET;
        end else begin
            state <= state_nxt;
        end
    end

    // Transitions
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_WAIT_RESET:  state_nxt = ST_PLL_RAMP;
            ST_PLL_RAMP:    if (pll_locked)     state_nxt = ST_CFR_HOLD;
            ST_CFR_HOLD:    if (!sys_fwd_reset) state_nxt = ST_TEST_START;
            ST_TEST_START:  state_nxt = ST_TEST_WAIT;
            ST_TEST_WAIT:   if (both_done)      state_nxt = ST_CFR_RELEASE;
            ST_CFR_RELEASE: if (!sys_fwd_reset) state_nxt = ST_CLK_DELAY;
            ST_CLK_DELAY:   if (delay_expired)  state_nxt = ST_RUN;
            ST_RUN:         state_nxt = ST_RUN;
            default:        state_nxt = ST_WAIT_RESET;
        endcase
    end

    // Sticky protocol-violation flag: line low when lock is accepted
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else if (state == ST_PLL_RAMP && pll_locked && !sys_fwd_reset) begin
            err_q <= 1'b1;
        end
    end

    // Outputs decoded from state
    always_comb begin
        rom_oe_n       = 1'b1;
        selftest_start = 1'b0;
        romload_start  = 1'b0;
        ext_clk_en     = 1'b0;
        core_run       = 1'b0;
        unique case (state)
            ST_CFR_HOLD:   rom_oe_n = 1'b0;
            ST_TEST_START: begin
                rom_oe_n       = 1'b0;
                selftest_start = 1'b1;
                romload_start  = 1'b1;
            end
            ST_TEST_WAIT:  rom_oe_n = 1'b0;
            ST_CLK_DELAY:  ext_clk_en = 1'b1;
            ST_RUN: begin
                ext_clk_en = 1'b1;
                core_run   = 1'b1;
            end
            default: ;
        endcase
        proto_err = err_q;
    end

    AST_OE_AFTER_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rom_oe_n) |-> $past(pll_locked)) else $error("ROM enable before lock"); // R2

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |=> proto_err) else $error("protocol flag dropped"); // R3

    AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        selftest_start |=> !selftest_start) else $error("start pulse too long"); // R5

    AST_CLK_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ext_clk_en) |-> !$past(sys_fwd_reset)) else $error("clock enabled while held"); // R8

    AST_RUN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        core_run |=> (core_run && ext_clk_en)) else $error("run dropped"); // R10

endmodule

// File: tb/boot_sequencer_bench.sv
`timescale 1ns/1ps
module boot_sequencer_bench;

    localparam int DELAY = 264;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_n, sys_fwd_reset, pll_locked, selftest_done, romload_done;
    logic rom_oe_n, selftest_start, romload_start, ext_clk_en, core_run, proto_err;

    int n_chk = 0;
    int n_bad = 0;

    boot_sequencer #(.DELAY_CYCLES(DELAY)) u_boot_sequencer (
        .clk(clk), .rst_n(rst_n), .sys_fwd_reset(sys_fwd_reset), .pll_locked(pll_locked),
        .selftest_done(selftest_done), .romload_done(romload_done),
        .rom_oe_n(rom_oe_n), .selftest_start(selftest_start), .romload_start(romload_start),
        .ext_clk_en(ext_clk_en), .core_run(core_run), .proto_err(proto_err)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int later_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int exp_oe_after(input int t, input int db, input int dr);
        return (t >= later_of(db, dr)) ? 1 : 0;
    endfunction

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    task automatic trial(input bit err, input int lockw, input int h1, input int db,
                         input int dr, input int h2, input bit early);
        rst_n = 1'b0; sys_fwd_reset = 1'($urandom % 2); pll_locked = 1'b0;
        selftest_done = 1'b0; romload_done = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 reset rom_oe_n", rom_oe_n, 1);
        chk("R1 reset starts", selftest_start | romload_start, 0);
        chk("R1 reset clk/run/err", ext_clk_en | core_run | proto_err, 0);
        rst_n = 1'b1;
        sys_fwd_reset = !err;
        @(negedge clk);
        for (int i = 0; i < lockw; i++) begin
            if (early) begin selftest_done = i[0]; romload_done = ~i[0]; end
            @(negedge clk);
            chk("R2 no ROM enable before lock", rom_oe_n, 1);
        end
        selftest_done = 1'b0; romload_done = 1'b0;
        pll_locked = 1'b1;
        @(negedge clk);
        chk("R2 ROM enable after lock", rom_oe_n, 0);
        chk("R3 protocol flag", proto_err, err);
        for (int i = 0; i < h1; i++) begin
            if (early) begin selftest_done = 1'b1; romload_done = 1'b1; end
            @(negedge clk);
            chk("R4 hold rom_oe_n", rom_oe_n, 0);
            chk("R4 no start while held", selftest_start | romload_start, 0);
        end
        selftest_done = 1'b0; romload_done = 1'b0;
        sys_fwd_reset = 1'b0;
        @(negedge clk);
        chk("R5 selftest_start", selftest_start, 1);
        chk("R5 romload_start", romload_start, 1);
        sys_fwd_reset = (h2 > 0);
        @(negedge clk);
        chk("R5 start pulse ends", selftest_start | romload_start, 0);
        for (int t = 0; t <= later_of(db, dr); t++) begin
            selftest_done = (t == db);
            romload_done  = (t == dr);
            @(negedge clk);
            chk("R6 R7 rom_oe_n vs done flags", rom_oe_n, exp_oe_after(t, db, dr));
            chk("R8 no clock during load", ext_clk_en, 0);
        end
        selftest_done = 1'b0; romload_done = 1'b0;
        for (int i = 0; i < h2; i++) begin
            @(negedge clk);
            chk("R8 clock held off", ext_clk_en, 0);
        end
        sys_fwd_reset = 1'b0;
        @(negedge clk);
        chk("R8 clock enabled", ext_clk_en, 1);
        for (int k = 1; k < DELAY; k++) begin
            sys_fwd_reset = 1'($urandom % 2);
            @(negedge clk);
            chk("R9 run before delay", core_run, 0);
        end
        @(negedge clk);
        chk("R9 run at delay", core_run, 1);
        for (int i = 0; i < 3; i++) begin
            sys_fwd_reset = ~sys_fwd_reset;
            pll_locked = 1'b0;
            @(negedge clk);
            chk("R10 run holds", core_run, 1);
            chk("R10 clock holds", ext_clk_en, 1);
            chk("R3 flag sticky", proto_err, err);
        end
        #3 rst_n = 1'b0;
        #1;
        chk("R1 async reset rom_oe_n", rom_oe_n, 1);
        chk("R1 async reset outputs", ext_clk_en | core_run | proto_err | selftest_start, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd20240));
        trial(0, 0, 0, 0, 0, 0, 0);
        trial(1, 3, 0, 2, 2, 1, 0);
        trial(0, 2, 3, 4, 1, 2, 1);
        trial(0, 1, 1, 1, 5, 0, 1);
        for (int n = 0; n < 16; n++) begin
            bit e, er;
            int lw, hh1, d1, d2, hh2;
            e   = ($urandom % 4) == 0;
            er  = !e && ($urandom % 2);
            lw  = $urandom % 6;
            hh1 = e ? 0 : int'($urandom % 5);
            d1  = er ? 1 + int'($urandom % 5) : int'($urandom % 6);
            d2  = er ? 1 + int'($urandom % 5) : int'($urandom % 6);
            hh2 = $urandom % 5;
            trial(e, lw, hh1, d1, d2, hh2, er);
        end
        summary();
        $finish;
    end

endmodule